// File: doc/BRIEF.md
# Break Occurrence Countdown Register

This block holds a programmable occurrence count for one debug break channel. Software loads a count through a simple register write port. While the execution-count mode is enabled, every qualifying break event on the channel lowers the count by one. The user-break interrupt request is raised only by the event that arrives once the count has come down to one, so a program can stop on the Nth occurrence of a break condition rather than the first.

A break event can be tagged as belonging to an instruction inside a very short repeat loop, where exceptions cannot be taken. Such events are dropped completely: they neither change the count nor request an interrupt. With the count mode disabled, break events go straight to the interrupt request and the stored count is left alone. Reads return the count zero-extended to the register width and have no side effects.

Top module: `brk_count_reg`

## Requirements
- R1: The count field is CNT_W bits wide (12 by default, so the largest programmable count is 4095); a write loads wrData[CNT_W-1:0] into it.
- R2: Register bits above the count field (bits 15:12 by default) always read as 0, and written values in those bits are discarded.
- R3: With countModeEn low, each break event not tagged inShortLoop raises breakIrq and leaves the count unchanged.
- R4: With countModeEn high, a break event not tagged inShortLoop, arriving while the count is greater than 1, lowers the count by one and raises no interrupt.
- R5: With countModeEn high, a qualifying event arriving while the count is 1 raises breakIrq and brings the count to 0; one arriving while the count is 0 raises breakIrq and leaves the count at 0.
- R6: A break event with inShortLoop high neither changes the count nor raises breakIrq, in either mode.
- R7: An active-low rstN clears the count to 0 and breakIrq to 0.
- R8: breakIrq is a registered pulse, high for exactly the one cycle after the clock edge that sampled the causing event, and low otherwise.
- R9: When wrEn and a break event coincide in one cycle, the write loads the count and the event is discarded: no decrement and no interrupt.
- R10: rdData always shows the current count, and reading never changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data, count zero-extended |
| countModeEn | input | 1 | Execution-count mode enable |
| breakEvent | input | 1 | One-cycle break condition pulse |
| inShortLoop | input | 1 | Event belongs to an instruction in a short repeat loop |
| breakIrq | output | 1 | One-cycle user-break interrupt request |

## Verification
The bench builds the block with its default parameters, a 16-bit register over a 12-bit count. That puts the full-scale load of 4095 and its discarded upper nibble within reach, alongside the small counts where the one-to-zero firing step and the event at zero are observed. Coincident write and event, suppressed loop events in both modes and a mid-run reset are driven as directed cases.

// File: rtl/brk_count_pkg.sv
package brk_count_pkg;
  typedef struct packed {
    logic load;   // take the bus value
    logic dec;    // lower the count by one
    logic fire;   // request the interrupt
  } cnt_strobe_t;
endpackage

// File: rtl/brk_count_ctrl.sv
module brk_count_ctrl
  import brk_count_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        countModeEn,
  input  logic        breakEvent,
  input  logic        inShortLoop,
  input  logic        countIsZero,
  input  logic        countIsOne,
  output cnt_strobe_t strobe,
  output logic        breakIrq
);
  logic qualEvent;

  always_comb begin
    qualEvent    = breakEvent && !inShortLoop && !wrEn;
    strobe.load  = wrEn;
    strobe.dec   = qualEvent && countModeEn && !countIsZero;
    strobe.fire  = qualEvent && (!countModeEn || countIsOne || countIsZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) breakIrq <= 1'b0;
    else       breakIrq <= strobe.fire;
  end

  // R6: loop-tagged events never request the interrupt
  assert_loop_no_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (breakEvent && inShortLoop) |=> !breakIrq);

  // R9: a coincident write swallows the event
  assert_write_wins_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !breakIrq);

  // R8: a pulse needs an event in the previous cycle
  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    !breakEvent |=> !breakIrq);
endmodule

// File: rtl/brk_count_dp.sv
module brk_count_dp
  import brk_count_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cnt_strobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic              countIsZero,
  output logic              countIsOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           count <= '0;
    else if (strobe.load) count <= wrData[CNT_W-1:0];
    else if (strobe.dec)  count <= count - ONE;
  end

  assign countIsZero = (count == '0);
  assign countIsOne  = (count == ONE);

  // R1: a write lands in the count field
  assert_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(wrData[CNT_W-1:0]));

  // R4: a decrement strobe lowers the count by exactly one
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load) |=> count == $past(count) - ONE);

  // R10: without load or decrement the count holds
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.dec) |=> $stable(count));
endmodule

// File: rtl/brk_count_reg.sv
module brk_count_reg
  import brk_count_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              countModeEn,
  input  logic              breakEvent,
  input  logic              inShortLoop,
  output logic              breakIrq
);
  localparam int PAD_W = DATA_W - CNT_W;

  cnt_strobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic             countIsZero;
  logic             countIsOne;

  brk_count_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .countModeEn(countModeEn),
    .breakEvent(breakEvent), .inShortLoop(inShortLoop),
    .countIsZero(countIsZero), .countIsOne(countIsOne),
    .strobe(strobe), .breakIrq(breakIrq)
  );

  brk_count_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .count(count), .countIsZero(countIsZero), .countIsOne(countIsOne)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdData = {{PAD_W{1'b0}}, count};
    end else begin : g_nopad
      assign rdData = count;
    end
  endgenerate

  // R5: an event at count one fires and empties the count
  assert_fire_at_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    (countModeEn && breakEvent && !inShortLoop && !wrEn && rdData == DATA_W'(1))
      |=> (breakIrq && rdData == '0));

  // R3: with the mode off, events leave the count alone
  assert_mode_off_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!countModeEn && !wrEn) |=> $stable(rdData));
endmodule

// File: tb/brk_count_reg_bench.sv
module brk_count_reg_bench;
  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic        mode;
    logic        ev;
    logic        loop;
    logic [15:0] expCount;
    logic        expIrq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, 16'h0003, 1'b0}, // R1 load
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0002, 1'b0}, // R4
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'h0002, 1'b0}, // R6 mode on
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0001, 1'b0}, // R4
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1}, // R5 at one
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1}, // R5 at zero
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0}, // R8 pulse ends
    '{1'b1, 16'hF005, 1'b1, 1'b0, 1'b0, 16'h0005, 1'b0}, // R2 upper dropped
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0005, 1'b1}, // R3 pass-through
    '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0005, 1'b0}, // R6 mode off
    '{1'b1, 16'h0002, 1'b1, 1'b1, 1'b0, 16'h0002, 1'b0}, // R9 write wins
    '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0002, 1'b0}, // R10 read idle
    '{1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 16'h0FFF, 1'b0}, // R1 max
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0FFE, 1'b0}, // R4 from max
    '{1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 16'h0001, 1'b0}, // R1
    '{1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1}  // R5
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        countModeEn = 1'b0;
  logic        breakEvent = 1'b0;
  logic        inShortLoop = 1'b0;
  logic        breakIrq;
  int          total = 0;
  int          bad = 0;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  brk_count_reg u_brk_count_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .countModeEn(countModeEn), .breakEvent(breakEvent),
    .inShortLoop(inShortLoop), .breakIrq(breakIrq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic [15:0] d, logic m, logic e, logic l);
    wrEn = w; wrData = d; countModeEn = m; breakEvent = e; inShortLoop = l;
    @(negedge clk);
    wrEn = 1'b0; breakEvent = 1'b0; inShortLoop = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R7 reset count", rdData, 16'h0000);
    check("R7 reset irq", {15'b0, breakIrq}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].data, VEC[i].mode, VEC[i].ev, VEC[i].loop);
      check($sformatf("vec%0d count", i), rdData, VEC[i].expCount);
      check($sformatf("vec%0d irq", i), {15'b0, breakIrq}, {15'b0, VEC[i].expIrq});
    end
    // R8: the interrupt is one cycle wide
    step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    check("R8 pulse width", {15'b0, breakIrq}, 16'h0000);
    // R10: repeated reads leave the count alone
    step(1'b1, 16'h0007, 1'b1, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 16'h0, 1'b1, 1'b0, 1'b0);
    check("R10 read no side effect", rdData, 16'h0007);
    // R2: upper bits stay zero after a full write
    step(1'b1, 16'hA00C, 1'b1, 1'b0, 1'b0);
    check("R2 upper bits", rdData, 16'h000C);
    // R7: reset mid-run clears the count
    rstN = 1'b0;
    @(negedge clk);
    check("R7 mid-run reset", rdData, 16'h0000);
    check("R7 mid-run irq", {15'b0, breakIrq}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule